// File: doc/BRIEF.md
# Fly-by DMA Peripheral Bus Bridge

This bridge sits between a fast system bus and a slow peripheral bus. For an ordinary register access it decodes the system address into one of several peripheral select lines. It then runs a peripheral cycle of one setup cycle followed by one strobe cycle, and holds the system bus in wait states until that cycle has finished.

When the DMA master owns the system bus and flags a DMA transaction, the bridge follows the memory-side transfer that the master makes. It produces the matching peripheral cycle so that data moves straight between memory and the peripheral, without a second bus transfer. In this mode the address is ignored and the peripheral direction is the reverse of the system-bus direction. The peripheral is selected by a dedicated per-channel DMA select line instead of by address decoding.

One channel, chosen by a parameter, serves a fast serial link. On that channel the bridge keeps the DMA select asserted between words. Every word after the first is strobed in the cycle right after its request, with no setup cycle.

Top module: `flyby_bridge`

## Requirements
- R1: In a normal access the bridge spends one setup cycle with exactly one address-decoded select high, then one strobe cycle. The select index is sys_addr bits [PAW+SW-1:PAW], per_addr carries sys_addr[PAW-1:0] and per_write equals sys_write. All selects drop after the strobe.
- R2: sys_ready stays low while a peripheral cycle is in progress. It pulses high for exactly one cycle, in the cycle after the strobe. For a peripheral read, sys_rdata then holds the per_rdata value that was present during the strobe.
- R3: In a DMA transfer per_write is the inverse of the sys_write value given with the request.
- R4: In a DMA transfer per_dma_sel[dma_chan] is the only DMA select high and every address-decoded select stays low.
- R5: In a DMA transfer the system address has no effect: per_addr is driven to zero.
- R6: A non-burst DMA channel gets a setup cycle and a strobe cycle for each word, and its DMA select drops in the cycle after the strobe. per_strobe is never high in two consecutive cycles.
- R7: On the burst channel (BURST_CH) the DMA select stays high between words. Each word after the first is strobed in the cycle right after its request is seen.
- R8: A burst ends in one of two ways. If the word carries dma_last, the DMA select drops in that word's ready cycle. If dma_active falls while the bridge waits between words, the select drops in the next cycle.
- R9: During the strobe of a peripheral write, per_wdata equals the sys_wdata given with the request.
- R10: After reset and whenever no transfer is in progress, all selects, DMA selects, per_strobe, per_write and sys_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | 1 | System-bus transfer request, held until sys_ready |
| sys_write | input | 1 | System-bus direction, 1 = write |
| sys_addr | input | AW | System-bus address |
| sys_wdata | input | DW | Data on the system bus toward the peripheral |
| sys_rdata | output | DW | Data returned from the peripheral |
| sys_ready | output | 1 | Transfer complete; low means wait state |
| dma_active | input | 1 | DMA master owns the bus with a DMA transaction flagged |
| dma_chan | input | CW | Peripheral channel served by the DMA transfer |
| dma_last | input | 1 | Current DMA word is the last of the transaction |
| per_addr | output | PAW | Peripheral address, zero during DMA |
| per_write | output | 1 | Peripheral direction, 1 = write to peripheral |
| per_strobe | output | 1 | Peripheral data strobe |
| per_wdata | output | DW | Write data to peripheral |
| per_rdata | input | DW | Read data from peripheral |
| per_sel | output | NSLOT | Address-decoded peripheral selects |
| per_dma_sel | output | NCH | Per-channel DMA selects |

## Verification
A wrong sequencer state shows at the ports within one cycle. A missed setup cycle or an extra one moves per_strobe and sys_ready by a cycle, and the bench compares both on every clock. A stale DMA flag or a wrong channel capture appears as the wrong select family or the wrong one-hot line while the word is in progress. A wrongly kept burst state leaves per_dma_sel high in the ready cycle of a last word, or one cycle after dma_active falls. A wrong direction capture flips per_write during the strobe, and a wrong data capture corrupts per_wdata or sys_rdata in the same transfer.

// File: rtl/flyby_bridge_pkg.sv
package flyby_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_DONE   = 3'd3,
    ST_HOLD   = 3'd4
  } brg_state_t;
endpackage

// File: rtl/flyby_seq.sv
module flyby_seq
  import flyby_bridge_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int CW       = 2,
  parameter int BURST_CH = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_req,
  input  logic          sys_write,
  input  logic [AW-1:0] sys_addr,
  input  logic [DW-1:0] sys_wdata,
  input  logic          dma_active,
  input  logic [CW-1:0] dma_chan,
  input  logic          dma_last,
  input  logic [DW-1:0] per_rdata,
  output brg_state_t    state,
  output logic          cap_dma,
  output logic [CW-1:0] cap_chan,
  output logic          cap_keep,
  output logic [AW-1:0] cap_addr,
  output logic          cap_write,
  output logic [DW-1:0] cap_wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [CW-1:0] BURST_IDX = CW'(BURST_CH);

  logic is_burst_ch;
  assign is_burst_ch = (dma_chan == BURST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cap_dma   <= 1'b0;
      cap_chan  <= '0;
      cap_keep  <= 1'b0;
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_wdata <= '0;
      rdata     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sys_req) begin
            cap_dma   <= dma_active;
            cap_chan  <= dma_chan;
            cap_keep  <= dma_active && is_burst_ch && !dma_last;
            cap_addr  <= sys_addr;
            cap_write <= dma_active ? !sys_write : sys_write;
            cap_wdata <= sys_wdata;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          if (!cap_write) rdata <= per_rdata;
          state <= ST_DONE;
        end
        ST_DONE: begin
          if (cap_dma && cap_keep) state <= ST_HOLD;
          else                     state <= ST_IDLE;
        end
        ST_HOLD: begin
          if (!dma_active) begin
            cap_dma  <= 1'b0;
            cap_keep <= 1'b0;
            state    <= ST_IDLE;
          end else if (sys_req) begin
            cap_write <= !sys_write;
            cap_wdata <= sys_wdata;
            cap_keep  <= !dma_last;
            state     <= ST_STROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flyby_sel_dec.sv
module flyby_sel_dec
  import flyby_bridge_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PAW   = 8,
  parameter int NSLOT = 4,
  parameter int NCH   = 3,
  parameter int CW    = 2
) (
  input  brg_state_t     state,
  input  logic           cap_dma,
  input  logic [CW-1:0]  cap_chan,
  input  logic           cap_keep,
  input  logic [AW-1:0]  cap_addr,
  input  logic           cap_write,
  output logic [NSLOT-1:0] per_sel,
  output logic [NCH-1:0] per_dma_sel,
  output logic [PAW-1:0] per_addr,
  output logic           per_write,
  output logic           per_strobe,
  output logic           sys_ready
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic          in_cycle;
  logic          dma_on;
  logic          norm_on;
  logic [SW-1:0] slot;

  assign in_cycle   = (state == ST_SETUP) || (state == ST_STROBE);
  assign norm_on    = in_cycle && !cap_dma;
  assign dma_on     = cap_dma && (in_cycle || (state == ST_HOLD) ||
                                  ((state == ST_DONE) && cap_keep));
  assign slot       = cap_addr[PAW +: SW];
  assign per_addr   = norm_on ? cap_addr[PAW-1:0] : '0;
  assign per_write  = in_cycle && cap_write;
  assign per_strobe = (state == ST_STROBE);
  assign sys_ready  = (state == ST_DONE);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign per_sel[s] = norm_on && (slot == SW'(s));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign per_dma_sel[c] = dma_on && (cap_chan == CW'(c));
  end
endmodule

// File: rtl/flyby_bridge.sv
module flyby_bridge
  import flyby_bridge_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int PAW      = 8,
  parameter int NSLOT    = 4,
  parameter int NCH      = 3,
  parameter int BURST_CH = 0,
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_req,
  input  logic             sys_write,
  input  logic [AW-1:0]    sys_addr,
  input  logic [DW-1:0]    sys_wdata,
  output logic [DW-1:0]    sys_rdata,
  output logic             sys_ready,
  input  logic             dma_active,
  input  logic [CW-1:0]    dma_chan,
  input  logic             dma_last,
  output logic [PAW-1:0]   per_addr,
  output logic             per_write,
  output logic             per_strobe,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata,
  output logic [NSLOT-1:0] per_sel,
  output logic [NCH-1:0]   per_dma_sel
);
  brg_state_t    state;
  logic          cap_dma;
  logic [CW-1:0] cap_chan;
  logic          cap_keep;
  logic [AW-1:0] cap_addr;
  logic          cap_write;

  flyby_seq #(
    .AW(AW), .DW(DW), .CW(CW), .BURST_CH(BURST_CH)
  ) u_seq (
    .clk(clk), .rst(rst),
    .sys_req(sys_req), .sys_write(sys_write), .sys_addr(sys_addr),
    .sys_wdata(sys_wdata), .dma_active(dma_active), .dma_chan(dma_chan),
    .dma_last(dma_last), .per_rdata(per_rdata),
    .state(state), .cap_dma(cap_dma), .cap_chan(cap_chan),
    .cap_keep(cap_keep), .cap_addr(cap_addr), .cap_write(cap_write),
    .cap_wdata(per_wdata), .rdata(sys_rdata)
  );

  flyby_sel_dec #(
    .AW(AW), .PAW(PAW), .NSLOT(NSLOT), .NCH(NCH), .CW(CW)
  ) u_dec (
    .state(state), .cap_dma(cap_dma), .cap_chan(cap_chan),
    .cap_keep(cap_keep), .cap_addr(cap_addr), .cap_write(cap_write),
    .per_sel(per_sel), .per_dma_sel(per_dma_sel), .per_addr(per_addr),
    .per_write(per_write), .per_strobe(per_strobe), .sys_ready(sys_ready)
  );
endmodule

// File: rtl/flyby_bridge_chk.sv
module flyby_bridge_chk #(
  parameter int PAW   = 8,
  parameter int NSLOT = 4,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_req,
  input logic             sys_write,
  input logic             sys_ready,
  input logic             dma_active,
  input logic [PAW-1:0]   per_addr,
  input logic             per_write,
  input logic             per_strobe,
  input logic [NSLOT-1:0] per_sel,
  input logic [NCH-1:0]   per_dma_sel
);
  // R1: one decoded select, stable across setup into strobe
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_sel));
  a_r1_setup_first: assert property (@(posedge clk) disable iff (rst)
    (per_strobe && |per_sel) |-> ($past(per_sel) == per_sel && !$past(per_strobe)));
  // R2: ready only follows a strobe
  a_r2_ready_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sys_ready |-> $past(per_strobe));
  // R3: direction inverted while the master holds its request
  a_r3_dir_inverted: assert property (@(posedge clk) disable iff (rst)
    (per_strobe && |per_dma_sel && sys_req) |-> (per_write == !sys_write));
  // R4: one DMA select, never mixed with decoded selects, raised only under DMA
  a_r4_dma_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_dma_sel));
  a_r4_no_mix: assert property (@(posedge clk) disable iff (rst)
    !(|per_sel && |per_dma_sel));
  a_r4_rise_under_dma: assert property (@(posedge clk) disable iff (rst)
    $rose(|per_dma_sel) |-> $past(dma_active));
  // R5: address zero during DMA
  a_r5_addr_zero: assert property (@(posedge clk) disable iff (rst)
    |per_dma_sel |-> (per_addr == '0));
  // R6: strobe lasts a single cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    per_strobe |=> !per_strobe);
endmodule

bind flyby_bridge flyby_bridge_chk #(
  .PAW(PAW), .NSLOT(NSLOT), .NCH(NCH)
) u_chk (
  .clk(clk), .rst(rst), .sys_req(sys_req), .sys_write(sys_write),
  .sys_ready(sys_ready), .dma_active(dma_active), .per_addr(per_addr),
  .per_write(per_write), .per_strobe(per_strobe), .per_sel(per_sel),
  .per_dma_sel(per_dma_sel)
);

// File: tb/sim_flyby_bridge.sv
`timescale 1ns/1ps
module sim_flyby_bridge;
  localparam int AW = 16, DW = 32, PAW = 8, NSLOT = 4, NCH = 3, BURST_CH = 0, CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          sys_req = 0, sys_write = 0, dma_active = 0, dma_last = 0;
  logic [AW-1:0] sys_addr = '0;
  logic [DW-1:0] sys_wdata = '0, per_rdata = '0;
  logic [CW-1:0] dma_chan = '0;
  logic [DW-1:0] sys_rdata, per_wdata;
  logic          sys_ready, per_write, per_strobe;
  logic [PAW-1:0] per_addr;
  logic [NSLOT-1:0] per_sel;
  logic [NCH-1:0] per_dma_sel;

  flyby_bridge #(.AW(AW), .DW(DW), .PAW(PAW), .NSLOT(NSLOT), .NCH(NCH),
                 .BURST_CH(BURST_CH)) u0 (
    .clk(clk), .rst(rst), .sys_req(sys_req), .sys_write(sys_write),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .sys_ready(sys_ready), .dma_active(dma_active), .dma_chan(dma_chan),
    .dma_last(dma_last), .per_addr(per_addr), .per_write(per_write),
    .per_strobe(per_strobe), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_sel(per_sel), .per_dma_sel(per_dma_sel)
  );

  typedef struct {
    logic          req, wr, dact, last;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd, prd;
    logic [CW-1:0] ch;
    logic          e_ready, e_strobe, e_write;
    logic [NSLOT-1:0] e_sel;
    logic [NCH-1:0] e_dsel;
    logic [PAW-1:0] e_addr;
    bit            chk_wd, chk_rd;
    logic [DW-1:0] e_wd, e_rd;
    string         tag;
  } step_t;

  step_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic step_t blank(logic req, logic wr, logic dact, logic [CW-1:0] ch,
                                  logic last, logic [AW-1:0] a, logic [DW-1:0] d,
                                  logic [DW-1:0] prd, string tag);
    step_t s;
    s.req = req; s.wr = wr; s.dact = dact; s.ch = ch; s.last = last;
    s.addr = a; s.wd = d; s.prd = prd; s.tag = tag;
    s.e_ready = 0; s.e_strobe = 0; s.e_write = 0; s.e_sel = '0; s.e_dsel = '0;
    s.e_addr = '0; s.chk_wd = 0; s.chk_rd = 0; s.e_wd = '0; s.e_rd = '0;
    return s;
  endfunction

  // first word of any access: setup, strobe, ready, then idle or hold
  task automatic word_first(bit dma, bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                            int ch, bit last, logic [DW-1:0] prd, string tag);
    step_t s;
    bit pw = dma ? !wr : wr;
    bit keep = dma && (ch == BURST_CH) && !last;
    logic [NSLOT-1:0] sel = dma ? '0 : (NSLOT'(1) << a[PAW +: 2]);
    logic [NCH-1:0] dsel = dma ? (NCH'(1) << ch) : '0;
    s = blank(1, wr, dma, CW'(ch), last, a, d, prd, tag);
    s.e_write = pw; s.e_sel = sel; s.e_dsel = dsel; s.e_addr = dma ? '0 : a[PAW-1:0];
    q.push_back(s);
    s.e_strobe = 1; s.chk_wd = pw; s.e_wd = d;
    q.push_back(s);
    s = blank(1, wr, dma, CW'(ch), last, a, d, prd, tag);
    s.e_ready = 1; s.e_dsel = keep ? dsel : '0; s.chk_rd = !pw; s.e_rd = prd;
    q.push_back(s);
    s = blank(0, wr, keep, CW'(ch), 0, a, d, prd, tag);
    s.e_dsel = keep ? dsel : '0;
    q.push_back(s);
  endtask

  // later burst word: strobe at once after request
  task automatic word_next(bit wr, logic [DW-1:0] d, bit last, logic [DW-1:0] prd, string tag);
    step_t s;
    logic [NCH-1:0] dsel = NCH'(1) << BURST_CH;
    s = blank(1, wr, 1, CW'(BURST_CH), last, 16'hFFFF, d, prd, tag);
    s.e_strobe = 1; s.e_write = !wr; s.e_dsel = dsel; s.chk_wd = !wr; s.e_wd = d;
    q.push_back(s);
    s = blank(1, wr, 1, CW'(BURST_CH), last, 16'hFFFF, d, prd, tag);
    s.e_ready = 1; s.e_dsel = last ? '0 : dsel; s.chk_rd = wr; s.e_rd = prd;
    q.push_back(s);
    s = blank(0, wr, !last, CW'(BURST_CH), 0, 16'hFFFF, d, prd, tag);
    s.e_dsel = last ? '0 : dsel;
    q.push_back(s);
  endtask

  task automatic drop_dma(string tag);
    q.push_back(blank(0, 0, 0, '0, 0, '0, '0, '0, tag));
    q.push_back(blank(0, 0, 0, '0, 0, '0, '0, '0, tag));
  endtask

  task automatic run_queue();
    while (q.size() > 0) begin
      step_t s = q.pop_front();
      sys_req = s.req; sys_write = s.wr; dma_active = s.dact; dma_chan = s.ch;
      dma_last = s.last; sys_addr = s.addr; sys_wdata = s.wd; per_rdata = s.prd;
      @(negedge clk);
      checks++;
      if (sys_ready !== s.e_ready || per_strobe !== s.e_strobe ||
          per_write !== s.e_write || per_sel !== s.e_sel ||
          per_dma_sel !== s.e_dsel || per_addr !== s.e_addr ||
          (s.chk_wd && per_wdata !== s.e_wd) || (s.chk_rd && sys_rdata !== s.e_rd)) begin
        errors++;
        $display("FAIL %s: got rdy=%b stb=%b wr=%b sel=%b dsel=%b pa=%h wd=%h rd=%h exp rdy=%b stb=%b wr=%b sel=%b dsel=%b pa=%h wd=%h rd=%h",
                 s.tag, sys_ready, per_strobe, per_write, per_sel, per_dma_sel, per_addr,
                 per_wdata, sys_rdata, s.e_ready, s.e_strobe, s.e_write, s.e_sel,
                 s.e_dsel, s.e_addr, s.e_wd, s.e_rd);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    checks++;
    if (sys_ready !== 0 || per_strobe !== 0 || per_write !== 0 || per_sel !== 0 || per_dma_sel !== 0) begin
      errors++;
      $display("FAIL R10 reset: rdy=%b stb=%b wr=%b sel=%b dsel=%b exp all zero",
               sys_ready, per_strobe, per_write, per_sel, per_dma_sel);
    end
    // R1 R9 normal write to slot 2; R2 R10 normal read slot 1
    word_first(0, 1, 16'h0234, 32'hCAFE_0001, 0, 0, 32'h0, "R1/R9 normal write");
    word_first(0, 0, 16'h01A5, 32'h0, 0, 0, 32'h1234_5678, "R2 normal read");
    // R3 R4 R5 R6 DMA chan 1, memory read feeds peripheral write
    word_first(1, 0, 16'h0377, 32'hD00D_0011, 1, 0, 32'h0, "R3/R5/R6 dma mem-to-per");
    // R3 R2 DMA chan 2, peripheral read feeds memory write
    word_first(1, 1, 16'h02C3, 32'h0, 2, 0, 32'h8765_4321, "R3/R4 dma per-to-mem");
    // R7 R8 burst ending on last flag
    word_first(1, 0, 16'h0111, 32'hB0B0_0001, BURST_CH, 0, 32'h0, "R7 burst first");
    word_next(0, 32'hB0B0_0002, 0, 32'h0, "R7 burst next");
    word_next(1, 32'h0, 1, 32'hAAAA_5555, "R8 burst last");
    // R8 burst ending on dma_active drop
    word_first(1, 0, 16'h0000, 32'hC1C1_0001, BURST_CH, 0, 32'h0, "R7 burst2 first");
    word_next(0, 32'hC1C1_0002, 0, 32'h0, "R7 burst2 next");
    drop_dma("R8 dma drop");
    // R8 single-word burst with last set
    word_first(1, 0, 16'h0300, 32'hE0E0_0001, BURST_CH, 1, 32'h0, "R8 single last");
    // R10 normal read with no DMA: dma selects stay low
    word_first(0, 0, 16'h03F0, 32'h0, 0, 0, 32'h0F0F_F0F0, "R10 normal after dma");
    run_queue();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule